// File: doc/BRIEF.md
# Weighted Two-Direction Code-Block Arbiter

This block shares one transfer path between an uplink (UL) and a downlink (DL) stream of code blocks. Each stream offers beats with a valid/ready handshake and marks the final beat of every code block with a last flag. The arbiter picks one stream at a time, forwards the handshake of that stream to the shared path, and changes streams only between code blocks.

When only one stream is requesting, it gets the path freely. When both request, the arbiter gives each stream a budget of whole code blocks. The budget is three blocks per unit of an 8-bit weight, one weight for each stream. Block length has no effect on the budget. The uplink spends its budget first. When both budgets are used up, a new round starts and both budgets are reloaded from the weight registers. A weight written in the middle of a round therefore applies from the next round.

Top module: `cba_arbiter`

## Requirements
- R1: After reset both weights are 1, both budgets hold 3 blocks, no block is in progress, and with no valid input both ready outputs and `out_valid_o` are 0.
- R2: While no block is in progress and only one stream is valid, that stream's ready equals `out_ready_i`. A spent budget does not block it, and blocks taken this way do not use up budget.
- R3: Once a non-last beat of a stream is accepted, that stream keeps the grant and the other stream's ready stays 0 until that stream's last beat is accepted.
- R4: A block uses up one unit of its stream's budget only if both streams were valid on its first accepted beat. Under steady contention a stream with weight w runs exactly 3·w consecutive blocks per round.
- R5: A block counts as one block whatever its number of beats.
- R6: A weight of 0 behaves as a weight of 1, which gives 3 blocks per round.
- R7: Weight writes (`wr_dir_i` 0 = UL, 1 = DL) apply at the next reload, which happens when the second budget reaches zero. Budgets already loaded are not changed by a write.
- R8: Under contention, with no block in progress, UL is granted while its budget is non-zero. Otherwise DL is granted.
- R9: `out_valid_o`, `out_last_o` and `out_dir_o` (0 = UL, 1 = DL) follow the granted stream. At most one ready is high, and a ready is high only when `out_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Weight write strobe |
| wr_dir_i | input | 1 | Selects the weight to write: 0 = UL, 1 = DL |
| wr_data_i | input | 8 | Weight value |
| ul_valid_i | input | 1 | UL beat valid |
| ul_last_i | input | 1 | UL last beat of a code block |
| ul_ready_o | output | 1 | UL beat accepted |
| dl_valid_i | input | 1 | DL beat valid |
| dl_last_i | input | 1 | DL last beat of a code block |
| dl_ready_o | output | 1 | DL beat accepted |
| out_valid_o | output | 1 | Shared path beat valid |
| out_last_o | output | 1 | Shared path last beat |
| out_dir_o | output | 1 | Stream that owns the current beat |
| out_ready_i | input | 1 | Shared path can accept a beat |

## Verification
The bench targets several corner cases, and each one shows a distinct failure.
- A weight written in the middle of a round: a design that reloads its budget at once changes how many blocks are left in the current round.
- A zero weight: a design that takes 0 literally either skips DL entirely or stalls the round.
- Multi-beat blocks under contention: a design that counts beats instead of blocks ends its UL run early.
- A lone requester: a design that lets the budget gate a lone requester drops its ready.
- Contention that starts in the middle of a block: a design that checks contention at the wrong beat charges the budget for a block that was not contended.

// File: rtl/cba_pkg.sv
package cba_pkg;
  typedef enum logic {
    DIR_UL = 1'b0,
    DIR_DL = 1'b1
  } dir_e;
endpackage

// File: rtl/cba_weight_regs.sv
module cba_weight_regs #(
  parameter int unsigned WEIGHT_W     = 8,
  parameter int unsigned RESET_WEIGHT = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     wr_dir_i,
  input  logic [WEIGHT_W-1:0]      wr_data_i,
  output logic [1:0][WEIGHT_W-1:0] weight_o
);
  for (genvar g = 0; g < 2; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        weight_o[g] <= WEIGHT_W'(RESET_WEIGHT);
      end else if (wr_en_i && (wr_dir_i == 1'(g))) begin
        weight_o[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/cba_credit.sv
module cba_credit #(
  parameter int unsigned WEIGHT_W     = 8,
  parameter int unsigned UNIT_BLOCKS  = 3,
  parameter int unsigned RESET_WEIGHT = 1,
  parameter int unsigned CREDIT_W     = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dec_i,
  input  logic                load_i,
  input  logic [WEIGHT_W-1:0] weight_i,
  output logic [CREDIT_W-1:0] credit_o,
  output logic                zero_o
);
  localparam int unsigned RST_UNITS = (RESET_WEIGHT == 0) ? 1 : RESET_WEIGHT;
  localparam logic [CREDIT_W-1:0] RST_CREDIT = CREDIT_W'(RST_UNITS * UNIT_BLOCKS);

  logic [CREDIT_W-1:0] units, load_val;

  // zero weight is promoted to one unit so no direction starves
  assign units    = (weight_i == '0) ? CREDIT_W'(1) : CREDIT_W'(weight_i);
  assign load_val = units * CREDIT_W'(UNIT_BLOCKS);
  assign zero_o   = (credit_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_o <= RST_CREDIT;
    end else if (load_i) begin
      credit_o <= load_val;
    end else if (dec_i && !zero_o) begin
      credit_o <= credit_o - CREDIT_W'(1);
    end
  end
endmodule

// File: rtl/cba_grant_sel.sv
module cba_grant_sel
  import cba_pkg::*;
(
  input  logic lock_i,
  input  dir_e own_i,
  input  logic ul_valid_i,
  input  logic dl_valid_i,
  input  logic ul_credit_nz_i,
  output logic gnt_vld_o,
  output dir_e gnt_dir_o
);
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_dir_o = DIR_UL;
    if (lock_i) begin
      gnt_vld_o = 1'b1;
      gnt_dir_o = own_i;
    end else if (ul_valid_i && dl_valid_i) begin
      gnt_vld_o = 1'b1;
      gnt_dir_o = ul_credit_nz_i ? DIR_UL : DIR_DL;
    end else if (ul_valid_i) begin
      gnt_vld_o = 1'b1;
      gnt_dir_o = DIR_UL;
    end else if (dl_valid_i) begin
      gnt_vld_o = 1'b1;
      gnt_dir_o = DIR_DL;
    end
  end
endmodule

// File: rtl/cba_block_track.sv
module cba_block_track
  import cba_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic last_i,
  input  dir_e dir_i,
  input  logic both_valid_i,
  output logic lock_o,
  output dir_e own_o,
  output logic count_o
);
  logic cont_q, cont_now;

  // contention is judged on the first beat of each block
  assign cont_now = lock_o ? cont_q : both_valid_i;
  assign count_o  = accept_i && last_i && cont_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      own_o  <= DIR_UL;
      cont_q <= 1'b0;
    end else if (accept_i) begin
      if (last_i) begin
        lock_o <= 1'b0;
      end else if (!lock_o) begin
        lock_o <= 1'b1;
        own_o  <= dir_i;
        cont_q <= both_valid_i;
      end
    end
  end
endmodule

// File: rtl/cba_arbiter.sv
module cba_arbiter
  import cba_pkg::*;
#(
  parameter int unsigned WEIGHT_W     = 8,
  parameter int unsigned UNIT_BLOCKS  = 3,
  parameter int unsigned RESET_WEIGHT = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_dir_i,
  input  logic [WEIGHT_W-1:0] wr_data_i,
  input  logic                ul_valid_i,
  input  logic                ul_last_i,
  output logic                ul_ready_o,
  input  logic                dl_valid_i,
  input  logic                dl_last_i,
  output logic                dl_ready_o,
  output logic                out_valid_o,
  output logic                out_last_o,
  output logic                out_dir_o,
  input  logic                out_ready_i
);
  localparam int unsigned CREDIT_MAX = ((1 << WEIGHT_W) - 1) * UNIT_BLOCKS;
  localparam int unsigned CREDIT_W   = $clog2(CREDIT_MAX + 1);

  logic [1:0][WEIGHT_W-1:0] weight;
  logic [1:0][CREDIT_W-1:0] credit;
  logic [1:0]               cr_zero;
  logic [1:0]               dec;
  logic [CREDIT_W-1:0]      credit_ul, credit_dl;
  logic                     lock, gnt_vld, accept, blk_cnt, reload, sel;
  dir_e                     own, gnt_dir;

  cba_weight_regs #(
    .WEIGHT_W    (WEIGHT_W),
    .RESET_WEIGHT(RESET_WEIGHT)
  ) u_weights (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_dir_i (wr_dir_i),
    .wr_data_i(wr_data_i),
    .weight_o (weight)
  );

  cba_grant_sel u_sel (
    .lock_i        (lock),
    .own_i         (own),
    .ul_valid_i    (ul_valid_i),
    .dl_valid_i    (dl_valid_i),
    .ul_credit_nz_i(!cr_zero[0]),
    .gnt_vld_o     (gnt_vld),
    .gnt_dir_o     (gnt_dir)
  );

  assign sel         = (gnt_dir == DIR_DL);
  assign out_dir_o   = sel;
  assign out_valid_o = gnt_vld && (sel ? dl_valid_i : ul_valid_i);
  assign out_last_o  = sel ? dl_last_i : ul_last_i;
  assign ul_ready_o  = gnt_vld && !sel && out_ready_i;
  assign dl_ready_o  = gnt_vld && sel && out_ready_i;
  assign accept      = out_valid_o && out_ready_i;

  cba_block_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .last_i      (out_last_o),
    .dir_i       (gnt_dir),
    .both_valid_i(ul_valid_i && dl_valid_i),
    .lock_o      (lock),
    .own_o       (own),
    .count_o     (blk_cnt)
  );

  // round ends when the last remaining credit is spent
  assign reload = blk_cnt && (credit[sel] == CREDIT_W'(1)) && cr_zero[!sel];

  for (genvar g = 0; g < 2; g++) begin : g_credit
    assign dec[g] = blk_cnt && (sel == 1'(g)) && !reload;
    cba_credit #(
      .WEIGHT_W    (WEIGHT_W),
      .UNIT_BLOCKS (UNIT_BLOCKS),
      .RESET_WEIGHT(RESET_WEIGHT),
      .CREDIT_W    (CREDIT_W)
    ) u_credit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dec_i   (dec[g]),
      .load_i  (reload),
      .weight_i(weight[g]),
      .credit_o(credit[g]),
      .zero_o  (cr_zero[g])
    );
  end

  assign credit_ul = credit[0];
  assign credit_dl = credit[1];
endmodule

// File: rtl/cba_arbiter_chk.sv
module cba_arbiter_chk #(
  parameter int unsigned CREDIT_W   = 10,
  parameter int unsigned CREDIT_MAX = 765
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ul_valid_i,
  input logic                dl_valid_i,
  input logic                ul_ready_o,
  input logic                dl_ready_o,
  input logic                out_valid_o,
  input logic                out_last_o,
  input logic                out_dir_o,
  input logic                out_ready_i,
  input logic                lock,
  input logic [CREDIT_W-1:0] credit_ul,
  input logic [CREDIT_W-1:0] credit_dl
);
  AST_EXCL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ul_ready_o && dl_ready_o)); // R9
  AST_READY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ul_ready_o || dl_ready_o) |-> out_ready_i); // R9
  AST_HOLD_UL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o && !out_dir_o) |=> !dl_ready_o); // R3
  AST_HOLD_DL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o && out_dir_o) |=> !ul_ready_o); // R3
  AST_SOLO_UL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock && ul_valid_i && !dl_valid_i) |-> (ul_ready_o == out_ready_i)); // R2
  AST_SOLO_DL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock && dl_valid_i && !ul_valid_i) |-> (dl_ready_o == out_ready_i)); // R2
  AST_UL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock && ul_valid_i && dl_valid_i && credit_ul != '0) |-> !dl_ready_o); // R8
  AST_CREDIT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_ul != '0) || (credit_dl != '0)); // R4
  AST_CREDIT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(credit_ul) <= CREDIT_MAX) && (32'(credit_dl) <= CREDIT_MAX)); // R4
endmodule

bind cba_arbiter cba_arbiter_chk #(
  .CREDIT_W  (CREDIT_W),
  .CREDIT_MAX(CREDIT_MAX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ul_valid_i (ul_valid_i),
  .dl_valid_i (dl_valid_i),
  .ul_ready_o (ul_ready_o),
  .dl_ready_o (dl_ready_o),
  .out_valid_o(out_valid_o),
  .out_last_o (out_last_o),
  .out_dir_o  (out_dir_o),
  .out_ready_i(out_ready_i),
  .lock       (lock),
  .credit_ul  (credit_ul),
  .credit_dl  (credit_dl)
);

// File: tb/tb_cba_arbiter.sv
`timescale 1ns/1ps
module tb_cba_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, wr_dir_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       ul_valid_i = 1'b0, ul_last_i = 1'b0, dl_valid_i = 1'b0, dl_last_i = 1'b0;
  logic       out_ready_i = 1'b0;
  logic       ul_ready_o, dl_ready_o, out_valid_o, out_last_o, out_dir_o;

  int tests = 0, fails = 0;

  // reference state built from the requirements
  int m_w[2], m_cr[2];
  bit m_lock, m_own, m_cont;
  bit seq[0:127];
  int seq_n, ul_beats;

  always #5 clk_i = ~clk_i;

  cba_arbiter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_dir_i(wr_dir_i),
    .wr_data_i(wr_data_i), .ul_valid_i(ul_valid_i), .ul_last_i(ul_last_i),
    .ul_ready_o(ul_ready_o), .dl_valid_i(dl_valid_i), .dl_last_i(dl_last_i),
    .dl_ready_o(dl_ready_o), .out_valid_o(out_valid_o), .out_last_o(out_last_o),
    .out_dir_o(out_dir_o), .out_ready_i(out_ready_i)
  );

  function automatic int blocks_of(int w);
    return ((w == 0) ? 1 : w) * 3;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    {wr_en_i, ul_valid_i, ul_last_i, dl_valid_i, dl_last_i, out_ready_i} = '0;
    m_w[0] = 1; m_w[1] = 1; m_cr[0] = 3; m_cr[1] = 3;
    m_lock = 0; m_own = 0; m_cont = 0; seq_n = 0; ul_beats = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic step(bit uv, bit ul, bit dv, bit dl, bit ordy,
                      bit we, bit wd, logic [7:0] wdat);
    bit gv, gs, eur, edr, eov, cont_now;
    string rtag;
    @(negedge clk_i);
    ul_valid_i = uv; ul_last_i = ul; dl_valid_i = dv; dl_last_i = dl;
    out_ready_i = ordy; wr_en_i = we; wr_dir_i = wd; wr_data_i = wdat;
    #1;
    gv = 1; gs = 0;
    if (m_lock) gs = m_own;
    else if (uv && dv) gs = (m_cr[0] != 0) ? 1'b0 : 1'b1;
    else if (uv) gs = 0;
    else if (dv) gs = 1;
    else gv = 0;
    eur = gv && !gs && ordy;
    edr = gv && gs && ordy;
    eov = gv && (gs ? dv : uv);
    rtag = m_lock ? "R3" : ((uv && dv) ? "R8" : "R2");
    check(rtag, "ul_ready", ul_ready_o, eur);
    check(rtag, "dl_ready", dl_ready_o, edr);
    check("R9", "out_valid", out_valid_o, eov);
    if (eov) begin
      check("R9", "out_dir", out_dir_o, gs);
      check("R9", "out_last", out_last_o, gs ? dl : ul);
    end
    if (out_valid_o && out_ready_i && out_last_o && seq_n < 128) begin
      seq[seq_n] = out_dir_o;
      seq_n++;
    end
    if (uv && ul_ready_o) ul_beats++;
    // advance the reference to the coming edge
    cont_now = m_lock ? m_cont : (uv && dv);
    if (eov && ordy) begin
      if (gs ? dl : ul) begin
        m_lock = 0;
        if (cont_now) begin
          m_cr[gs]--;
          if (m_cr[0] == 0 && m_cr[1] == 0) begin
            m_cr[0] = blocks_of(m_w[0]);
            m_cr[1] = blocks_of(m_w[1]);
          end
        end
      end else if (!m_lock) begin
        m_lock = 1; m_own = gs; m_cont = uv && dv;
      end
    end
    if (we) m_w[wd] = wdat;
  endtask

  task automatic count_dir(string tag, int from, int to, bit dir);
    int n = 0;
    for (int i = from; i <= to; i++) if (seq[i] == dir) n++;
    check(tag, $sformatf("blocks of dir %0d in [%0d..%0d]", dir, from, to), n, to - from + 1);
  endtask

  initial begin
    process::self().srandom(32'h1234_5678);
    do_reset();
    #1;
    check("R1", "idle ul_ready", ul_ready_o, 0);
    check("R1", "idle dl_ready", dl_ready_o, 0);
    check("R1", "idle out_valid", out_valid_o, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    check("R1", "ready with no request", ul_ready_o | dl_ready_o, 0);

    // default weights, steady contention: UL first, 3 then 3 (R8, R4, R1)
    for (int i = 0; i < 12; i++) step(1, 1, 1, 1, 1, 0, 0, 0);
    check("R4", "blocks seen", seq_n, 12);
    count_dir("R8", 0, 2, 0);
    count_dir("R4", 3, 5, 1);
    count_dir("R4", 6, 8, 0);
    count_dir("R4", 9, 11, 1);

    // mid-round write (R7) and zero weight (R6)
    seq_n = 0;
    step(1, 1, 1, 1, 1, 1, 0, 8'd2);
    step(1, 1, 1, 1, 1, 1, 1, 8'd0);
    for (int i = 0; i < 13; i++) step(1, 1, 1, 1, 1, 0, 0, 0);
    count_dir("R7", 0, 2, 0);
    count_dir("R7", 3, 5, 1);
    count_dir("R7", 6, 11, 0);
    count_dir("R6", 12, 14, 1);

    // four-beat UL blocks count as single blocks (R5)
    seq_n = 0; ul_beats = 0;
    for (int i = 0; i < 60 && seq_n < 9; i++)
      step(1, (ul_beats % 4) == 3, 1, 1, 1, 0, 0, 0);
    check("R5", "UL beats in run", ul_beats, 24);
    count_dir("R5", 0, 5, 0);
    count_dir("R5", 6, 8, 1);

    // lone DL with throttled path, never blocked by budget (R2)
    for (int i = 0; i < 20; i++) step(0, 0, 1, ($urandom % 2) == 1, ($urandom % 4) != 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0, 0, 0);
    check("R2", "lone DL ready", dl_ready_o, 1);

    // contention arising mid-block is not charged (R4)
    step(0, 0, 1, 0, 1, 0, 0, 0);
    step(1, 0, 1, 1, 1, 0, 0, 0);
    seq_n = 0;
    for (int i = 0; i < 12; i++) step(1, 1, 1, 1, 1, 0, 0, 0);
    count_dir("R4", 0, 5, 0);
    count_dir("R4", 6, 8, 1);

    // random traffic with occasional weight writes
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 64) == 0;
      step(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 4) != 0,
           ($urandom % 3) == 0, ($urandom % 5) != 0, we, $urandom % 2,
           8'($urandom % 6));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule